// File: doc/BRIEF.md
# Simple Dual-Port Synchronous RAM

This block is a word-addressed memory with a dedicated write side and a dedicated read side. The write side stores one word per rising edge of its clock while its enable is high. The read side returns the addressed word from a read data register. A parameter either gives the read side its own clock or drives both sides from the write clock. The block is meant for alignment and delay buffers. A typical use writes a stream at one address pointer and reads it back at an offset pointer.

The collision behaviour is set by a parameter. In the default no-change mode, a read that hits the word being written in the same cycle leaves the read data register untouched. In read-first mode, the same read returns the word as it was before the write. Read-first requires the shared clock, and elaboration stops with an error if it is combined with independent clocks. A second parameter adds one output pipeline stage after the read data register. The address width is derived from the depth unless a parameter asks for a fixed 32-bit address port.

Top module: `sdp_ram`

## Requirements
- R1: When `wr_en` is high at a rising edge of `clk_a`, `wr_data` is stored at the word selected by `wr_addr`. When `wr_en` is low, memory is unchanged.
- R2: When `rd_en` is high at a rising edge of the read clock, the word at `rd_addr` appears on `rd_data` after that edge. This is one cycle of latency when `OUT_REG` is 0.
- R3: With `OUT_REG` = 1, `rd_data` shows the read data register one read-clock cycle later. Read latency becomes two cycles.
- R4: While `rd_en` is low, the read data register and `rd_data` keep their value.
- R5: With the default mode (`READ_FIRST` = 0) and a shared clock, a read of the address being written in the same cycle leaves the read data register unchanged. The next read of that address returns the new word.
- R6: With `READ_FIRST` = 1, a read of the address being written in the same cycle returns the word held before the write.
- R7: With `SAME_CLK` = 0, reads are clocked by `clk_b` and return words written earlier through `clk_a`.
- R8: A synchronous `rst`, high at a read-clock edge, clears the read data register and the output stage to zero. Memory contents are kept.
- R9: With `ADDR_AUTO` = 0, both address ports are 32 bits wide. Only the low log2(`DEPTH`) bits select the word, and the upper bits are ignored.

| Parameter | Default | Meaning |
|---|---|---|
| `DATA_W` | 16 | width of a stored word |
| `DEPTH` | 256 | number of words |
| `ADDR_AUTO` | 1 | 1: address width from `DEPTH`; 0: 32-bit address ports |
| `SAME_CLK` | 1 | 1: both sides use `clk_a`; 0: read side uses `clk_b` |
| `READ_FIRST` | 0 | 0: no-change mode; 1: read-first mode (shared clock only) |
| `OUT_REG` | 0 | 1: adds the output pipeline stage |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | write clock; also the read clock when `SAME_CLK` = 1 |
| clk_b | input | 1 | read clock when `SAME_CLK` = 0 |
| rst | input | 1 | synchronous clear of the read-side registers, read clock domain |
| wr_en | input | 1 | write strobe |
| wr_addr | input | ADDR_W | write word address |
| wr_data | input | DATA_W | word to store |
| rd_en | input | 1 | read strobe |
| rd_addr | input | ADDR_W | read word address |
| rd_data | output | DATA_W | read word |

## Verification
Four instances are driven side by side: the default, a read-first variant, a pipelined variant and a two-clock variant with 32-bit addresses.
- Back-to-back reads of freshly written words show the latency of each configuration. Comparing the default against the pipelined instance isolates the one extra cycle.
- Same-address write-and-read cycles separate no-change from read-first. The first holds the earlier output and the second returns the stale word.
- Idle read cycles show that the output holds.
- Simultaneous traffic to different addresses and to the top word shows that collisions are decided by address match alone.
- Reads on the slower second clock, with junk in the upper address bits, show that only the low address bits take part.

// File: rtl/sdp_ram.sv
module sdp_ram #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 256,
  parameter int ADDR_AUTO  = 1,
  parameter int SAME_CLK   = 1,
  parameter int READ_FIRST = 0,
  parameter int OUT_REG    = 0,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W = (ADDR_AUTO != 0) ? IDX_W : 32
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  generate
    if (READ_FIRST != 0 && SAME_CLK == 0) begin : g_bad_mode
      $error("sdp_ram: read-first mode needs SAME_CLK = 1");
    end
  endgenerate

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic              rclk;
  logic [IDX_W-1:0]  wi, ri;
  logic              collide;

  assign rclk    = (SAME_CLK != 0) ? clk_a : clk_b;
  assign wi      = wr_addr[IDX_W-1:0];
  assign ri      = rd_addr[IDX_W-1:0];
  assign collide = (SAME_CLK != 0) && (READ_FIRST == 0) && wr_en && (wi == ri);

  always_ff @(posedge clk_a)
    if (wr_en) mem[wi] <= wr_data;

  always_ff @(posedge rclk)
    if (rst)                    dout_q <= '0;
    else if (rd_en && !collide) dout_q <= mem[ri];

  generate
    if (OUT_REG != 0) begin : g_pipe
      logic [DATA_W-1:0] pipe_q;
      always_ff @(posedge rclk)
        if (rst) pipe_q <= '0;
        else     pipe_q <= dout_q;
      assign rd_data = pipe_q;
    end else begin : g_direct
      assign rd_data = dout_q;
    end
  endgenerate

endmodule

module sdp_ram_chk #(
  parameter int DATA_W     = 16,
  parameter int NC_COLLIDE = 1,
  parameter int OUT_REG    = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              same_addr,
  input logic [DATA_W-1:0] dout_q,
  input logic [DATA_W-1:0] rd_data
);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(dout_q));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  generate
    if (NC_COLLIDE != 0) begin : g_nc
      p_nochange_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && same_addr) |=> $stable(dout_q));
    end
    if (OUT_REG != 0) begin : g_pl
      p_pipe_delay_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rd_data == $past(dout_q)));
    end
  endgenerate

endmodule

bind sdp_ram sdp_ram_chk #(
  .DATA_W(DATA_W),
  .NC_COLLIDE((SAME_CLK != 0 && READ_FIRST == 0) ? 1 : 0),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .same_addr(wi == ri), .dout_q(dout_q), .rd_data(rd_data)
);

// File: tb/sdp_ram_tb.sv
`timescale 1ns/1ps
module sdp_ram_tb;
  typedef struct {
    int          when;
    int          which;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic clk_a = 0, clk_b = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0, dc_ren = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [31:0] dc_raddr = 0;
  logic [15:0] d_nc, d_rf, d_pl, d_dc;
  int cyc = 0, checks = 0, fails = 0;
  item_t q[$];
  logic [15:0] model [256];
  logic [15:0] nc_h = 0, rf_h = 0;
  bit done = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;
  always @(posedge clk_a) cyc <= cyc + 1;

  sdp_ram u_dut (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d_nc));
  sdp_ram #(.READ_FIRST(1)) u_dut_rf (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d_rf));
  sdp_ram #(.OUT_REG(1)) u_dut_pl (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d_pl));
  sdp_ram #(.SAME_CLK(0), .ADDR_AUTO(0)) u_dut_dc (.clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .wr_en(wr_en), .wr_addr({24'hA5A5A5, wr_addr}), .wr_data(wr_data), .rd_en(dc_ren),
    .rd_addr(dc_raddr), .rd_data(d_dc));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_a) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].when == cyc) begin
        case (q[i].which)
          0: chk(q[i].req, d_nc, q[i].exp);
          1: chk(q[i].req, d_rf, q[i].exp);
          default: chk(q[i].req, d_pl, q[i].exp);
        endcase
        q.delete(i);
      end
    end
  end

  task automatic op(input logic we, input logic [7:0] wa, input logic [15:0] wd,
                    input logic re, input logic [7:0] ra, input string tag);
    item_t it;
    bit hit;
    @(negedge clk_a);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    hit = we && re && (wa == ra);
    if (re && !hit) nc_h = model[ra];
    if (re) rf_h = model[ra];
    it.when = cyc + 1; it.which = 0; it.exp = nc_h; it.req = hit ? "R5" : tag; q.push_back(it);
    it.which = 1; it.exp = rf_h; it.req = hit ? "R6" : tag; q.push_back(it);
    it.when = cyc + 2; it.which = 2; it.exp = nc_h; it.req = "R3"; q.push_back(it);
    if (we) model[wa] = wd;
  endtask

  task automatic dc_read(input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk_b);
    dc_ren = 1; dc_raddr = {24'h3C3C3C, a};
    @(posedge clk_b);
    #1 dc_ren = 0;
    chk("R7/R9", d_dc, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (6) @(negedge clk_a);
    rst = 0;
    @(negedge clk_a);
    chk("R8", d_nc, 16'h0); chk("R8", d_rf, 16'h0);
    chk("R8", d_pl, 16'h0); chk("R8", d_dc, 16'h0);
    for (int i = 0; i < 8; i++) op(1, 8'(i), 16'(100 + 3 * i), 0, 0, "R4");
    op(1, 8'hFF, 16'hF00D, 0, 0, "R4");
    for (int i = 0; i < 8; i++) op(0, 0, 0, 1, 8'(i), "R2");
    op(0, 0, 0, 1, 8'hFF, "R2");
    op(0, 0, 0, 0, 3, "R4");
    op(0, 0, 0, 0, 4, "R4");
    op(1, 5, 16'hBEEF, 1, 5, "R5");
    op(0, 0, 0, 1, 5, "R5");
    op(0, 0, 0, 1, 2, "R2");
    op(1, 9, 16'h1234, 1, 9, "R5");
    op(0, 9, 16'hDEAD, 1, 9, "R1");
    op(1, 6, 16'hCAFE, 1, 7, "R1");
    op(0, 0, 0, 1, 6, "R1");
    op(1, 8'hFF, 16'h7E57, 1, 8'hFF, "R6");
    op(0, 0, 0, 1, 8'hFF, "R2");
    for (int i = 0; i < 4; i++) op(0, 0, 0, 0, 0, "R4");
    while (q.size() != 0) @(negedge clk_a);
    dc_read(0, 16'd100);
    dc_read(5, 16'hBEEF);
    dc_read(8'hFF, 16'h7E57);
    dc_read(6, 16'hCAFE);
    @(negedge clk_b);
    chk("R4", d_dc, 16'hCAFE);
    done = 1;
    finish_run();
  end
endmodule